// File: doc/BRIEF.md
# Domain-Based Peripheral Access Checker

This block decides, in the same cycle as a request, whether a bus master may read or write a given peripheral. Each master is mapped to one of four domains by a small programmable table. Each peripheral has a policy entry that grants read and write permission separately for each domain. A request carries the master number, the peripheral number and the direction. The block looks up the master's domain and the matching permission bit, and it drives either allow or deny.

Both tables sit behind a simple configuration port: one write strobe, a table select, an entry index and a 16-bit data word, with a combinational read-back of the selected entry. Every entry has its own lock bit. Once the lock is set, the entry is frozen until reset, so boot firmware can fix the mapping for good. Policy entries also hold a semaphore-request enable flag, which is stored and read back only. A read-only information word reports how many masters, domains and peripherals the instance has. The asynchronous reset input passes through an internal synchronizer, so the reset is released on a clock edge.

Top module: `periph_access_guard`

## Requirements
- R1: After reset every master entry reads back domain 0 with lock clear (read word 0x0000). The master read word holds the domain in bits [1:0] and the lock in bit 15. All other bits read as 0.
- R2: After reset every policy entry reads back permission 0xFF with lock and semaphore enable clear (read word 0x00FF). The policy read word holds the permission byte in bits [7:0], the semaphore enable in bit 14 and the lock in bit 15.
- R3: A write with select 0 to an unlocked master entry stores data bits [1:0] as the domain and bit 15 as the lock. The new value is visible from the next clock.
- R4: A write with select 1 to an unlocked policy entry stores data bits [7:0] as the permission, bit 14 as the semaphore enable and bit 15 as the lock. In the permission byte, bit 2d grants write and bit 2d+1 grants read for domain d (d = 0..3).
- R5: For a valid request, acc_allow is 1 exactly when the policy bit of the addressed peripheral, for the domain of the requesting master and the request direction, is 1. acc_deny is its complement, and both respond in the same cycle as the request.
- R6: A master entry with its lock set ignores all further writes until reset. After a new reset the entry is back to its reset value.
- R7: A policy entry with its lock set ignores all further writes until reset.
- R8: A write to a master index at or above N_MASTERS, or to a policy index at or above N_PERIPH, changes no entry. Reading such an index returns 0.
- R9: Select 2 reads the information word: bits [3:0] hold the master count, bits [7:4] the domain count (4) and bits [15:8] the peripheral count. Writes with select 2 or 3 change nothing. Select 3 reads as 0.
- R10: A valid request whose master index is at or above N_MASTERS, or whose peripheral index is at or above N_PERIPH, is denied.
- R11: When acc_valid is 0, both acc_allow and acc_deny are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, synchronized internally |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Table select: 0 masters, 1 policies, 2 information, 3 none |
| cfg_idx | input | IDX_W (4) | Entry index, used for writes and read-back |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read-back of the selected entry |
| acc_valid | input | 1 | Access request present |
| acc_master | input | MST_W (3) | Requesting master index |
| acc_periph | input | PER_W (4) | Target peripheral index |
| acc_write | input | 1 | 1 for a write request, 0 for a read request |
| acc_allow | output | 1 | Request permitted |
| acc_deny | output | 1 | Request refused |

## Verification
For every table state, the access path is swept over all master and peripheral index codes, including the out-of-range codes, and over both directions. Expected results come from a bench model of the tables. The sweep is run first on the reset policies, which grant everything and so isolate the index-range checks. It is then run on a distinct pseudo-random permission byte per peripheral with each master in its own domain, which separates the domain lookup from the direction bit. A final run after a master has been remapped under lock shows that frozen entries still steer the decision. Between these runs, full read-backs of both tables, taken after writes to locked entries, to out-of-range indices and to the information select, show which writes landed and which did not.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int DOM_N    = 4;
  localparam int DOM_W    = 2;
  localparam int PERM_W   = 2 * DOM_N;
  localparam int REG_W    = 16;
  localparam int LOCK_BIT = 15;
  localparam int SEMA_BIT = 14;

  typedef enum logic [1:0] {
    SEL_MASTER = 2'd0,
    SEL_POLICY = 2'd1,
    SEL_INFO   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic             lock;
    logic [DOM_W-1:0] dom;
  } mst_ent_t;

  typedef struct packed {
    logic              lock;
    logic              sema;
    logic [PERM_W-1:0] perm;
  } pol_ent_t;
endpackage

// File: rtl/pag_rst_sync.sv
module pag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pag_mst_table.sv
module pag_mst_table
  import pag_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  mst_ent_t           wr_ent,
  output mst_ent_t [N-1:0]   ents
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    mst_ent_t ent_q;
    mst_ent_t ent_d;
    logic     ent_ld;

    always_comb begin
      ent_ld = wr_en && (wr_idx == IDX_W'(i)) && !ent_q.lock;
      ent_d  = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_ld) ent_q <= ent_d;
    end

    assign ents[i] = ent_q;

    // R6: a locked entry never changes while out of reset
    assert_mst_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ent_q.lock |=> $stable(ent_q));

    // R3: an accepted write is visible on the next clock
    assert_mst_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IDX_W'(i)) && !ent_q.lock) |=> (ent_q == $past(wr_ent)));
  end
endmodule

// File: rtl/pag_pol_table.sv
module pag_pol_table
  import pag_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  pol_ent_t           wr_ent,
  output pol_ent_t [N-1:0]   ents
);
  localparam pol_ent_t POL_RESET = '{lock: 1'b0, sema: 1'b0, perm: {PERM_W{1'b1}}};

  for (genvar i = 0; i < N; i++) begin : g_ent
    pol_ent_t ent_q;
    pol_ent_t ent_d;
    logic     ent_ld;

    always_comb begin
      ent_ld = wr_en && (wr_idx == IDX_W'(i)) && !ent_q.lock;
      ent_d  = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= POL_RESET;
      else if (ent_ld) ent_q <= ent_d;
    end

    assign ents[i] = ent_q;

    // R7: a locked policy never changes while out of reset
    assert_pol_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ent_q.lock |=> $stable(ent_q));

    // R4: an accepted write is visible on the next clock
    assert_pol_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == IDX_W'(i)) && !ent_q.lock) |=> (ent_q == $past(wr_ent)));
  end
endmodule

// File: rtl/pag_perm_check.sv
module pag_perm_check
  import pag_pkg::*;
#(
  parameter int N_M   = 4,
  parameter int N_P   = 8,
  parameter int MST_W = 3,
  parameter int PER_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mst_ent_t [N_M-1:0]   mst,
  input  pol_ent_t [N_P-1:0]   pol,
  input  logic                 acc_valid,
  input  logic [MST_W-1:0]     acc_master,
  input  logic [PER_W-1:0]     acc_periph,
  input  logic                 acc_write,
  output logic                 acc_allow,
  output logic                 acc_deny
);
  localparam int MI_W = $clog2(N_M);
  localparam int PI_W = $clog2(N_P);

  logic              m_ok;
  logic              p_ok;
  logic [DOM_W-1:0]  dom;
  logic [PERM_W-1:0] perm;
  logic              grant;

  always_comb begin
    m_ok  = acc_master < MST_W'(N_M);
    p_ok  = acc_periph < PER_W'(N_P);
    dom   = m_ok ? mst[acc_master[MI_W-1:0]].dom : '0;
    perm  = p_ok ? pol[acc_periph[PI_W-1:0]].perm : '0;
    grant = perm[{dom, ~acc_write}];
    acc_allow = acc_valid && m_ok && p_ok && grant;
    acc_deny  = acc_valid && !acc_allow;
  end

  // R5: a valid request gets exactly one answer
  assert_one_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_allow != acc_deny));

  // R10: out-of-range master or peripheral is refused
  assert_range_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ((acc_master >= MST_W'(N_M)) || (acc_periph >= PER_W'(N_P)))) |-> acc_deny);

  // R11: no request, no answer
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_allow && !acc_deny));
endmodule

// File: rtl/periph_access_guard.sv
module periph_access_guard
  import pag_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_PERIPH  = 8,
  parameter int MST_W     = $clog2(N_MASTERS) + 1,
  parameter int PER_W     = $clog2(N_PERIPH) + 1,
  parameter int IDX_W     = (MST_W > PER_W) ? MST_W : PER_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              acc_valid,
  input  logic [MST_W-1:0]  acc_master,
  input  logic [PER_W-1:0]  acc_periph,
  input  logic              acc_write,
  output logic              acc_allow,
  output logic              acc_deny
);
  localparam int MI_W = $clog2(N_MASTERS);
  localparam int PI_W = $clog2(N_PERIPH);
  localparam logic [REG_W-1:0] INFO_WORD = {8'(N_PERIPH), 4'(DOM_N), 4'(N_MASTERS)};

  logic                     rst_n;
  cfg_sel_e                 sel;
  mst_ent_t                 mst_wr;
  pol_ent_t                 pol_wr;
  mst_ent_t [N_MASTERS-1:0] mst_ents;
  pol_ent_t [N_PERIPH-1:0]  pol_ents;
  logic                     unused_wbits;

  pag_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  always_comb begin
    sel          = cfg_sel_e'(cfg_sel);
    mst_wr       = '{lock: cfg_wdata[LOCK_BIT], dom: cfg_wdata[DOM_W-1:0]};
    pol_wr       = '{lock: cfg_wdata[LOCK_BIT], sema: cfg_wdata[SEMA_BIT],
                     perm: cfg_wdata[PERM_W-1:0]};
    unused_wbits = ^cfg_wdata[SEMA_BIT-1:PERM_W];
  end

  pag_mst_table #(.N(N_MASTERS), .IDX_W(IDX_W)) i_mst_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we && (sel == SEL_MASTER)),
    .wr_idx (cfg_idx),
    .wr_ent (mst_wr),
    .ents   (mst_ents)
  );

  pag_pol_table #(.N(N_PERIPH), .IDX_W(IDX_W)) i_pol_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we && (sel == SEL_POLICY)),
    .wr_idx (cfg_idx),
    .wr_ent (pol_wr),
    .ents   (pol_ents)
  );

  pag_perm_check #(.N_M(N_MASTERS), .N_P(N_PERIPH), .MST_W(MST_W), .PER_W(PER_W)) i_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .mst        (mst_ents),
    .pol        (pol_ents),
    .acc_valid  (acc_valid),
    .acc_master (acc_master),
    .acc_periph (acc_periph),
    .acc_write  (acc_write),
    .acc_allow  (acc_allow),
    .acc_deny   (acc_deny)
  );

  always_comb begin
    cfg_rdata = '0;
    unique case (sel)
      SEL_MASTER: if (cfg_idx < IDX_W'(N_MASTERS)) begin
        cfg_rdata[LOCK_BIT]    = mst_ents[cfg_idx[MI_W-1:0]].lock;
        cfg_rdata[DOM_W-1:0]   = mst_ents[cfg_idx[MI_W-1:0]].dom;
      end
      SEL_POLICY: if (cfg_idx < IDX_W'(N_PERIPH)) begin
        cfg_rdata[LOCK_BIT]    = pol_ents[cfg_idx[PI_W-1:0]].lock;
        cfg_rdata[SEMA_BIT]    = pol_ents[cfg_idx[PI_W-1:0]].sema;
        cfg_rdata[PERM_W-1:0]  = pol_ents[cfg_idx[PI_W-1:0]].perm;
      end
      SEL_INFO:   cfg_rdata = INFO_WORD;
      default:    cfg_rdata = '0;
    endcase
  end

  // R9: the information word never moves while out of reset
  assert_info_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_INFO) |-> (cfg_rdata == INFO_WORD));
endmodule

// File: tb/test_periph_access_guard.sv
module test_periph_access_guard;
  localparam int NM    = 4;
  localparam int NP    = 8;
  localparam int MST_W = 3;
  localparam int PER_W = 4;
  localparam int IDX_W = 4;
  localparam int HALF  = 2;  // 4 ns period, 250 MHz

  logic              clk = 1'b0;
  logic              arst_n;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [IDX_W-1:0]  cfg_idx;
  logic [15:0]       cfg_wdata;
  logic [15:0]       cfg_rdata;
  logic              acc_valid;
  logic [MST_W-1:0]  acc_master;
  logic [PER_W-1:0]  acc_periph;
  logic              acc_write;
  logic              acc_allow;
  logic              acc_deny;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0] m_dom [NM];
  bit         m_lck [NM];
  logic [7:0] p_perm[NP];
  bit         p_sem [NP];
  bit         p_lck [NP];

  always #HALF clk = ~clk;

  periph_access_guard i_periph_access_guard (
    .clk(clk), .arst_n(arst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_master(acc_master), .acc_periph(acc_periph), .acc_write(acc_write),
    .acc_allow(acc_allow), .acc_deny(acc_deny)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NM; i++) begin m_dom[i] = 2'd0; m_lck[i] = 0; end
    for (int i = 0; i < NP; i++) begin p_perm[i] = 8'hFF; p_sem[i] = 0; p_lck[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int idx, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0 && idx < NM && !m_lck[idx]) begin
      m_dom[idx] = data[1:0]; m_lck[idx] = data[15];
    end
    if (sel == 2'd1 && idx < NP && !p_lck[idx]) begin
      p_perm[idx] = data[7:0]; p_sem[idx] = data[14]; p_lck[idx] = data[15];
    end
  endtask

  function automatic logic [15:0] exp_read(input int sel, input int idx);
    if (sel == 0) return (idx < NM) ? {m_lck[idx], 13'd0, m_dom[idx]} : 16'd0;
    if (sel == 1) return (idx < NP) ? {p_lck[idx], p_sem[idx], 6'd0, p_perm[idx]} : 16'd0;
    if (sel == 2) return {8'(NP), 4'd4, 4'(NM)};
    return 16'd0;
  endfunction

  task automatic read_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 16; i++) begin
        cfg_sel = 2'(s); cfg_idx = IDX_W'(i);
        #1;
        check($sformatf("%s sel%0d idx%0d", tag, s, i), 32'(cfg_rdata), 32'(exp_read(s, i)));
      end
    end
  endtask

  task automatic sweep_access(input string tag);
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 16; p++) begin
        for (int w = 0; w < 2; w++) begin
          logic ok;
          ok = 1'b0;
          if (m < NM && p < NP) ok = p_perm[p][2*m_dom[m] + (w ? 0 : 1)];
          acc_valid = 1'b1; acc_master = MST_W'(m); acc_periph = PER_W'(p); acc_write = w[0];
          #1;
          check($sformatf("%s allow m%0d p%0d w%0d", tag, m, p, w), 32'(acc_allow), 32'(ok));
          check($sformatf("%s deny m%0d p%0d w%0d", tag, m, p, w), 32'(acc_deny), 32'(!ok));
        end
      end
    end
    acc_valid = 1'b0;
  endtask

  task automatic sweep_idle();
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 16; p++) begin
        acc_valid = 1'b0; acc_master = MST_W'(m); acc_periph = PER_W'(p); acc_write = p[0];
        #1;
        check($sformatf("R11 idle m%0d p%0d", m, p), 32'({acc_allow, acc_deny}), 32'd0);
      end
    end
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_idx = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_master = '0; acc_periph = '0; acc_write = 1'b0;
    do_reset();

    // R1, R2, R9: reset contents and information word
    read_all("R1 R2 R9 reset");
    // R5, R10: default policies grant all in-range requests
    sweep_access("R5 R10 default");
    sweep_idle();

    // R3, R4: each master in its own domain, distinct permission bytes
    for (int i = 0; i < NM; i++) cfg_write(2'd0, i, 16'(i));
    for (int i = 0; i < NP; i++)
      cfg_write(2'd1, i, {1'b0, i[0], 6'd0, 8'((i * 8'h3B) ^ 8'hA5)});
    read_all("R3 R4 programmed");
    sweep_access("R5 programmed");

    // R6: lock master 2 in domain 1, then try to move it
    cfg_write(2'd0, 2, 16'h8001);
    cfg_write(2'd0, 2, 16'h0003);
    cfg_write(2'd0, 2, 16'h8002);
    // R7: lock policy 5, then try to open it
    cfg_write(2'd1, 5, 16'hC012);
    cfg_write(2'd1, 5, 16'h00FF);
    read_all("R6 R7 locked");
    sweep_access("R5 R6 R7 locked");

    // R8: out-of-range writes; R9: writes to info and unused select
    for (int i = NM; i < 16; i++) cfg_write(2'd0, i, 16'h8003);
    for (int i = NP; i < 16; i++) cfg_write(2'd1, i, 16'hC000);
    for (int i = 0; i < 16; i++) cfg_write(2'd2, i, 16'h0000);
    for (int i = 0; i < 16; i++) cfg_write(2'd3, i, 16'hFFFF);
    read_all("R8 R9 ignored writes");
    sweep_access("R8 R10 after ignored");

    // R6: locks clear on reset
    do_reset();
    read_all("R6 R7 relocked reset");
    cfg_write(2'd0, 2, 16'h0003);
    cfg_write(2'd1, 5, 16'h0000);
    read_all("R6 R7 writable after reset");
    sweep_access("R5 after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule